// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block is a small fully associative cache of virtual-to-physical page translations. Each entry stores a virtual page number, the identifier of the process that owns the mapping, a page frame number, permission bits and extra flag bits. A lookup presents a full virtual address and the current process identifier. The tag comparison is combinational across all entries: a hit returns the physical address (frame number joined to the untouched page offset) plus the entry's permission and flag bits in the same cycle, while a miss is reported instead.

After a miss, the surrounding walker fetches the mapping from the page table and installs it through the fill port. Because entries are tagged with a process identifier, a context switch does not require emptying the cache. Software can still clear everything in one cycle, or clear only the entries of one process, for example after it edits that process's mappings or protection flags. Two counters record how many lookups hit and how many missed.

Top module: `xlat_tag_cache`

## Requirements
- R1: The lookup address is split into a page number (upper `VA_W-PAGE_OFF_W` bits, default 20) and an offset (low `PAGE_OFF_W` bits, default 12). On a hit, `lk_pa` equals `{frame, offset}` in the same cycle as the request.
- R2: A hit requires a valid entry whose page number and process tag both equal the request. With `lk_valid` high, exactly one of `lk_hit` and `lk_miss` is high. Both are low when `lk_valid` is low. On a miss, `lk_pa`, `lk_perm` and `lk_flags` are zero. At most one entry ever matches a given page and process pair.
- R3: A fill whose page and process already sit in a valid entry overwrites that entry. Otherwise the fill goes into the lowest-numbered invalid entry.
- R4: A fill that finds no matching and no invalid entry replaces the entry named by a rotating pointer. The pointer starts at entry 0 after reset, advances by one after each such replacement, and wraps after the last entry.
- R5: `flush_all` makes every entry invalid at the next clock edge, so a lookup one cycle later misses.
- R6: `flush_pid_en` invalidates exactly the entries whose process tag equals `flush_pid`. Entries of other processes keep hitting.
- R7: A fill presented in a cycle where either flush input is high is dropped and installs nothing.
- R8: `hit_cnt` and `miss_cnt` count the cycles in which `lk_valid` was high and the lookup hit or missed. Their values appear one cycle after the lookup, and they wrap at their width. A scan of 2048 consecutive 4-byte words starting on a page boundary, with each miss filled before the next lookup, adds exactly 2 misses and 2046 hits.
- R9: After reset, every entry is invalid and both counters read zero.
- R10: On a hit, `lk_perm` and `lk_flags` return the permission and flag bits written by the fill that created the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | VA_W (32) | Virtual address to translate |
| lk_pid | input | PID_W (8) | Current process identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup missed |
| lk_pa | output | PFN_W+PAGE_OFF_W (32) | Translated physical address |
| lk_perm | output | PERM_W (3) | Permission bits of the hit entry |
| lk_flags | output | FLAG_W (2) | Flag bits of the hit entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VA_W-PAGE_OFF_W (20) | Page number of the fill |
| fill_pid | input | PID_W (8) | Owning process of the fill |
| fill_pfn | input | PFN_W (20) | Frame number of the fill |
| fill_perm | input | PERM_W (3) | Permission bits of the fill |
| fill_flags | input | FLAG_W (2) | Flag bits of the fill |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate the entries of one process |
| flush_pid | input | PID_W (8) | Process whose entries are invalidated |
| hit_cnt | output | CNT_W (32) | Lookups that hit |
| miss_cnt | output | CNT_W (32) | Lookups that missed |

## Verification
The directed phase first fills every entry with one process's pages and then keeps filling past capacity. This separates the free-slot choice from rotating replacement, and it shows an overwrite of an existing page leaving its neighbours in place. The same page is then presented under a different process identifier to show that the process tag takes part in the match. A per-process flush is paired with entries of two processes, and a fill is made to collide with a flush, to show which entries survive. A sequential word scan across two pages checks that only page crossings miss. A long random phase works over a small page and process space, so overwrites, evictions, selective flushes and lookups interleave densely. A behavioural model checks every output on every cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // source of the slot chosen for a fill
   typedef enum logic [1:0] {
      SLOT_REUSE = 2'd0,
      SLOT_FREE  = 2'd1,
      SLOT_EVICT = 2'd2
   } slot_src_e;
endpackage

// File: rtl/xlat_cam_match.sv
module xlat_cam_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8
) (
   input  logic [ENTRIES-1:0]            valid_vec,
   input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr,
   input  logic [ENTRIES-1:0][PID_W-1:0] pid_arr,
   input  logic [VPN_W-1:0]              key_vpn,
   input  logic [PID_W-1:0]              key_pid,
   output logic [ENTRIES-1:0]            match_vec
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid_vec[g] &&
                            (vpn_arr[g] == key_vpn) &&
                            (pid_arr[g] == key_pid);
   end
endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] key_match,
   input  logic               fill_go,
   output logic [IDX_W-1:0]   slot
);
   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] match_idx;
   logic [IDX_W-1:0] free_idx;
   logic             any_free;
   slot_src_e        src;

   // lowest invalid entry wins
   always_comb begin
      free_idx = '0;
      any_free = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
      end
   end

   always_comb begin
      match_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (key_match[i]) match_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (|key_match) begin
         src  = SLOT_REUSE;
         slot = match_idx;
      end else if (any_free) begin
         src  = SLOT_FREE;
         slot = free_idx;
      end else begin
         src  = SLOT_EVICT;
         slot = rr_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             rr_q <= '0;
      else if (fill_go && src == SLOT_EVICT)  rr_q <= rr_q + 1'b1;
   end

   // R4: the rotating pointer moves by exactly one per replacement
   a_r4_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && src == SLOT_EVICT) |=> rr_q == $past(rr_q) + 1'b1);
   // R4: no move without a replacement
   a_r4_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_go && src == SLOT_EVICT) |=> $stable(rr_q));
   // R3: an existing pair is never placed twice
   a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(key_match));
endmodule

// File: rtl/xlat_event_count.sv
module xlat_event_count #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 2) begin : g_bad_w
      $error("xlat_event_count: CNT_W must be at least 2");
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  count <= '0;
         else if (inc && ~&count)     count <= count + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   count <= '0;
         else if (inc) count <= count + 1'b1;
      end
      // R8: each counted event adds one, modulo the width
      a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
         inc |=> count == $past(count) + 1'b1);
   end

   a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
endmodule

// File: rtl/xlat_tag_cache.sv
module xlat_tag_cache #(
   parameter int VA_W       = 32,
   parameter int PAGE_OFF_W = 12,
   parameter int PFN_W      = 20,
   parameter int PID_W      = 8,
   parameter int PERM_W     = 3,
   parameter int FLAG_W     = 2,
   parameter int ENTRIES    = 8,
   parameter int CNT_W      = 32,
   localparam int VPN_W     = VA_W - PAGE_OFF_W,
   localparam int PA_W      = PFN_W + PAGE_OFF_W,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [PID_W-1:0]  lk_pid,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [PA_W-1:0]   lk_pa,
   output logic [PERM_W-1:0] lk_perm,
   output logic [FLAG_W-1:0] lk_flags,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PID_W-1:0]  fill_pid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic [FLAG_W-1:0] fill_flags,
   input  logic              flush_all,
   input  logic              flush_pid_en,
   input  logic [PID_W-1:0]  flush_pid,
   output logic [CNT_W-1:0]  hit_cnt,
   output logic [CNT_W-1:0]  miss_cnt
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("xlat_tag_cache: ENTRIES must be a power of two, at least 2");
   end
   if (PAGE_OFF_W < 1 || PAGE_OFF_W >= VA_W) begin : g_bad_split
      $error("xlat_tag_cache: PAGE_OFF_W must lie inside VA_W");
   end

   logic [ENTRIES-1:0]             ent_valid;
   logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
   logic [ENTRIES-1:0][PID_W-1:0]  ent_pid;
   logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
   logic [ENTRIES-1:0][PERM_W-1:0] ent_perm;
   logic [ENTRIES-1:0][FLAG_W-1:0] ent_flags;

   logic [VPN_W-1:0]       lk_vpn;
   logic [PAGE_OFF_W-1:0]  lk_off;
   logic [ENTRIES-1:0]     lk_match;
   logic [ENTRIES-1:0]     fill_match;
   logic [ENTRIES-1:0]     wr_vec;
   logic [IDX_W-1:0]       fill_slot;
   logic                   fill_go;
   logic                   any_hit;
   logic [PFN_W-1:0]       sel_pfn;
   logic [PERM_W-1:0]      sel_perm;
   logic [FLAG_W-1:0]      sel_flags;

   assign lk_vpn  = lk_va[VA_W-1:PAGE_OFF_W];
   assign lk_off  = lk_va[PAGE_OFF_W-1:0];
   assign fill_go = fill_valid && !flush_all && !flush_pid_en;

   xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_cam (
      .valid_vec (ent_valid),
      .vpn_arr   (ent_vpn),
      .pid_arr   (ent_pid),
      .key_vpn   (lk_vpn),
      .key_pid   (lk_pid),
      .match_vec (lk_match)
   );

   xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fill_cam (
      .valid_vec (ent_valid),
      .vpn_arr   (ent_vpn),
      .pid_arr   (ent_pid),
      .key_vpn   (fill_vpn),
      .key_pid   (fill_pid),
      .match_vec (fill_match)
   );

   xlat_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_vec (ent_valid),
      .key_match (fill_match),
      .fill_go   (fill_go),
      .slot      (fill_slot)
   );

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         wr_vec[i] = fill_go && (fill_slot == IDX_W'(i));
      end
   end

   // entry storage: flushes dominate writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_valid <= '0;
         ent_vpn   <= '0;
         ent_pid   <= '0;
         ent_pfn   <= '0;
         ent_perm  <= '0;
         ent_flags <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (flush_all) begin
               ent_valid[i] <= 1'b0;
            end else if (flush_pid_en && ent_pid[i] == flush_pid) begin
               ent_valid[i] <= 1'b0;
            end else if (wr_vec[i]) begin
               ent_valid[i] <= 1'b1;
               ent_vpn[i]   <= fill_vpn;
               ent_pid[i]   <= fill_pid;
               ent_pfn[i]   <= fill_pfn;
               ent_perm[i]  <= fill_perm;
               ent_flags[i] <= fill_flags;
            end
         end
      end
   end

   // one-hot match drives an OR mux
   always_comb begin
      sel_pfn   = '0;
      sel_perm  = '0;
      sel_flags = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) begin
            sel_pfn   = sel_pfn   | ent_pfn[i];
            sel_perm  = sel_perm  | ent_perm[i];
            sel_flags = sel_flags | ent_flags[i];
         end
      end
   end

   assign any_hit  = |lk_match;
   assign lk_hit   = lk_valid && any_hit;
   assign lk_miss  = lk_valid && !any_hit;
   assign lk_pa    = lk_hit ? {sel_pfn, lk_off} : '0;
   assign lk_perm  = lk_hit ? sel_perm  : '0;
   assign lk_flags = lk_hit ? sel_flags : '0;

   xlat_event_count #(.CNT_W(CNT_W), .SATURATE(1'b0)) u_hit_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (lk_hit),
      .count (hit_cnt)
   );

   xlat_event_count #(.CNT_W(CNT_W), .SATURATE(1'b0)) u_miss_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (lk_miss),
      .count (miss_cnt)
   );

   // R2: the stored pairs stay unique
   a_r2_unique_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   // R2: hit and miss are never raised together
   a_r2_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss));
   // R5: a global flush leaves nothing valid
   a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> ent_valid == '0);
   // R7: no entry becomes valid during a flush
   a_r7_no_fill_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all || flush_pid_en) |=> $countones(ent_valid) <= $countones($past(ent_valid)));

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent_chk
      // R6: tagged entries of the flushed process are gone
      a_r6_pid_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (flush_pid_en && ent_pid[g] == flush_pid) |=> !ent_valid[g]);
      // R3: a written entry is valid afterwards
      a_r3_write_valid: assert property (@(posedge clk) disable iff (!rst_n)
         wr_vec[g] |=> ent_valid[g]);
   end
endmodule

// File: tb/test_xlat_tag_cache.sv
`timescale 1ns/1ps
module test_xlat_tag_cache;
   localparam int NE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_pid = '0;
   logic        lk_hit, lk_miss;
   logic [31:0] lk_pa;
   logic [2:0]  lk_perm;
   logic [1:0]  lk_flags;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [7:0]  fill_pid = '0;
   logic [19:0] fill_pfn = '0;
   logic [2:0]  fill_perm = '0;
   logic [1:0]  fill_flags = '0;
   logic        flush_all = 1'b0;
   logic        flush_pid_en = 1'b0;
   logic [7:0]  flush_pid = '0;
   logic [31:0] hit_cnt, miss_cnt;

   always #4 clk = ~clk;

   xlat_tag_cache i_xlat_tag_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_pid(lk_pid),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa),
      .lk_perm(lk_perm), .lk_flags(lk_flags),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
      .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_flags(fill_flags),
      .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid),
      .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
   );

   // behavioural reference
   bit        m_v[NE];
   bit [19:0] m_vpn[NE];
   bit [7:0]  m_pid[NE];
   bit [19:0] m_pfn[NE];
   bit [2:0]  m_perm[NE];
   bit [1:0]  m_flags[NE];
   int        m_rr = 0;
   bit [31:0] m_hits = 0, m_misses = 0;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   function automatic int m_find(bit [19:0] vpn, bit [7:0] pid);
      for (int i = 0; i < NE; i++)
         if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
      return -1;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      int mi;
      bit eh;
      mi = m_find(lk_va[31:12], lk_pid);
      eh = lk_valid && (mi >= 0);
      chk("R2 (state via R3 R4 R5 R6 R7)", "hit", 64'(lk_hit), 64'(eh));
      chk("R2", "miss", 64'(lk_miss), 64'(lk_valid && mi < 0));
      chk("R1", "pa", 64'(lk_pa), eh ? 64'({m_pfn[mi], lk_va[11:0]}) : 64'd0);
      chk("R10", "perm", 64'(lk_perm), eh ? 64'(m_perm[mi]) : 64'd0);
      chk("R10", "flags", 64'(lk_flags), eh ? 64'(m_flags[mi]) : 64'd0);
      chk("R8", "hit_cnt", 64'(hit_cnt), 64'(m_hits));
      chk("R8", "miss_cnt", 64'(miss_cnt), 64'(m_misses));
   endtask

   task automatic m_update();
      int idx;
      if (lk_valid) begin
         if (m_find(lk_va[31:12], lk_pid) >= 0) m_hits++;
         else m_misses++;
      end
      if (flush_all) begin
         for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
      end else if (flush_pid_en) begin
         for (int i = 0; i < NE; i++) if (m_pid[i] == flush_pid) m_v[i] = 1'b0;
      end else if (fill_valid) begin
         idx = m_find(fill_vpn, fill_pid);
         if (idx < 0)
            for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) idx = i;
         if (idx < 0) begin
            idx = m_rr;
            m_rr = (m_rr + 1) % NE;
         end
         m_v[idx] = 1'b1;     m_vpn[idx] = fill_vpn; m_pid[idx] = fill_pid;
         m_pfn[idx] = fill_pfn; m_perm[idx] = fill_perm; m_flags[idx] = fill_flags;
      end
   endtask

   task automatic tick();
      #1 compare_all();
      @(posedge clk);
      m_update();
      @(negedge clk);
   endtask

   task automatic idle();
      lk_valid = 0; fill_valid = 0; flush_all = 0; flush_pid_en = 0;
   endtask

   task automatic look(input bit [31:0] va, input bit [7:0] pid);
      idle(); lk_valid = 1; lk_va = va; lk_pid = pid;
   endtask

   task automatic fill(input bit [19:0] vpn, input bit [7:0] pid, input bit [19:0] pfn,
                       input bit [2:0] perm, input bit [1:0] fl);
      idle(); fill_valid = 1; fill_vpn = vpn; fill_pid = pid;
      fill_pfn = pfn; fill_perm = perm; fill_flags = fl;
      tick();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      bit [31:0] h0, m0;
      for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: empty after reset
      look(32'h1234_5678, 8'd1);
      #1 chk("R9", "miss after reset", 64'(lk_miss), 64'd1);
      chk("R9", "hit_cnt at reset", 64'(hit_cnt), 64'd0);
      tick();

      for (int i = 0; i < NE; i++)
         fill(20'h100 + 20'(i), 8'd1, 20'h800 + 20'(i), 3'(i), 2'(i));
      look(32'h0010_3ABC, 8'd1);
      #1 chk("R1", "pa of page 0x103", 64'(lk_pa), 64'h0080_3ABC);
      chk("R10", "perm of page 0x103", 64'(lk_perm), 64'd3);
      tick();

      // R3: overwrite in place
      fill(20'h105, 8'd1, 20'h999, 3'd7, 2'd0);
      look(32'h0010_0000, 8'd1);
      #1 chk("R3", "neighbour kept", 64'(lk_hit), 64'd1);
      tick();
      look(32'h0010_5010, 8'd1);
      #1 chk("R3", "new frame", 64'(lk_pa), 64'h0099_9010);
      tick();

      // R4: rotating replacement starts at entry 0
      fill(20'h200, 8'd1, 20'h700, 3'd1, 2'd1);
      look(32'h0010_0000, 8'd1);
      #1 chk("R4", "entry 0 evicted", 64'(lk_miss), 64'd1);
      tick();
      look(32'h0010_1000, 8'd1);
      #1 chk("R4", "entry 1 kept", 64'(lk_hit), 64'd1);
      tick();
      fill(20'h201, 8'd1, 20'h701, 3'd1, 2'd1);
      look(32'h0010_1000, 8'd1);
      #1 chk("R4", "entry 1 evicted next", 64'(lk_miss), 64'd1);
      tick();

      // R2: process tag takes part
      look(32'h0010_2000, 8'd2);
      #1 chk("R2", "other pid misses", 64'(lk_miss), 64'd1);
      tick();

      // R6: selective flush
      fill(20'h300, 8'd2, 20'h333, 3'd2, 2'd2);
      idle(); flush_pid_en = 1; flush_pid = 8'd1; tick();
      look(32'h0030_0444, 8'd2);
      #1 chk("R6", "pid 2 survives", 64'(lk_pa), 64'h0033_3444);
      tick();
      look(32'h0010_3000, 8'd1);
      #1 chk("R6", "pid 1 cleared", 64'(lk_miss), 64'd1);
      tick();

      // R7: fill dropped under flush
      idle(); flush_pid_en = 1; flush_pid = 8'd9;
      fill_valid = 1; fill_vpn = 20'h500; fill_pid = 8'd4; fill_pfn = 20'h555;
      tick();
      look(32'h0050_0000, 8'd4);
      #1 chk("R7", "dropped fill", 64'(lk_miss), 64'd1);
      tick();

      // R5: global flush
      idle(); flush_all = 1; tick();
      look(32'h0030_0000, 8'd2);
      #1 chk("R5", "empty after flush", 64'(lk_miss), 64'd1);
      tick();

      // R8: sequential scan over two pages
      idle(); tick();
      h0 = hit_cnt; m0 = miss_cnt;
      for (int i = 0; i < 2048; i++) begin
         bit [31:0] va;
         bit was_miss;
         va = 32'h1000 + 32'(i) * 4;
         look(va, 8'd5);
         was_miss = (m_find(va[31:12], 8'd5) < 0);
         tick();
         if (was_miss) fill(va[31:12], 8'd5, 20'h40 + va[31:12], 3'd5, 2'd3);
      end
      idle(); #1
      chk("R8", "scan misses", 64'(miss_cnt - m0), 64'd2);
      chk("R8", "scan hits", 64'(hit_cnt - h0), 64'd2046);
      tick();

      // random interleaving
      for (int c = 0; c < 4000; c++) begin
         int r;
         idle();
         lk_valid = ($urandom_range(0, 3) != 0);
         lk_va = {16'h0, 4'($urandom_range(0, 15)), 12'($urandom)};
         lk_pid = 8'($urandom_range(0, 3));
         fill_valid = ($urandom_range(0, 9) < 3);
         fill_vpn = 20'($urandom_range(0, 15));
         fill_pid = 8'($urandom_range(0, 3));
         fill_pfn = 20'($urandom);
         fill_perm = 3'($urandom);
         fill_flags = 2'($urandom);
         r = $urandom_range(0, 99);
         flush_all = (r < 2);
         flush_pid_en = (r >= 2 && r < 7);
         flush_pid = 8'($urandom_range(0, 3));
         tick();
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule